// File: doc/BRIEF.md
# Compute-Array Host Register Bank

This block is the host-facing register bank of a small compute-in-memory tile. An SPI mode 0 slave receives 16-bit frames, most significant bit first. Each frame carries a direction bit, a 7-bit register address and an 8-bit data byte. The bank decodes each finished frame into a compact register map. It owns the bit-cell array of weights and the activation vector, and it exports both to the compute and self-test engines. It reads back the accumulator, the per-row mismatch bytes and the fault counter that those engines produce.

The control register does not store its command bits. Writing a command bit emits a pulse that lasts one clock, and the bit reads back as zero. The status register keeps three sticky flags: self-test finished, compute finished, and a fault seen at any time. The engines set these flags with one-cycle strobes. The host clears a flag by writing a one to its bit. An interrupt line goes high when it is enabled and either finished flag is set.

The SPI pins are sampled through a synchroniser into the system clock. All frame decoding runs on the system clock. A frame cut short by chip-select going high has no effect.

Top module: `crim_regbank`

## Requirements
- R1: A frame is 16 bits: the direction bit (1 = read, 0 = write), then a 7-bit address, then 8 data bits, all MSB first in SPI mode 0. On a read, the addressed register's value comes out on `spi_miso` MSB first over clocks 9 to 16, ready before each rising SCK edge.
- R2: A write to 0x02 sets the row pointer. Address 0x03 reads or writes the cell row that the pointer selects. Row r of the array appears on `cells_o[r*COLS +: COLS]`. A pointer at or above ROWS reads 0x00 at 0x03, and writes to 0x03 then change no row.
- R3: Address 0x04 holds the activation byte. It reads back as written, and its low ROWS bits drive `act_vec_o`.
- R4: 0x05 and 0x06 read the low and high bytes of `accum_i`. A write to 0x07 sets the fault-row pointer. 0x08 reads `fault_map_i[p*COLS +: COLS]` for that pointer p. 0x09 reads `fault_cnt_i`.
- R5: Control register 0x00 works as follows. Bit 0 pulses `start_bist_o`, bit 1 pulses `start_cim_o` and bit 2 pulses `clear_fault_o`, each high for exactly one clock per write and reading back 0. Bit 7 is the stored interrupt enable.
- R6: Status register 0x01 has bit 5 = self-test done, bit 6 = compute done, bit 7 = any-fault and bit 0 = `busy_i`. Each sticky bit is set by its strobe input and cleared by writing 1 to that bit. A written 0 leaves a flag unchanged, and a strobe wins over a clear in the same clock.
- R7: The cycle after `clear_fault_o` pulses, the any-fault flag is cleared.
- R8: `irq_o` is high exactly when the interrupt enable is set and the self-test-done or compute-done flag is set.
- R9: A frame in which chip-select rises before the 16th bit writes nothing.
- R10: Addresses outside 0x00 to 0x09 read 0x00, and writes to them change no register.
- R11: After reset all registers, flags, pulses and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host |
| busy_i | input | 1 | Either engine running |
| bist_done_set_i | input | 1 | Self-test finished strobe |
| cim_done_set_i | input | 1 | Compute finished strobe |
| fault_set_i | input | 1 | Non-zero mismatch strobe |
| accum_i | input | ACC_W | Compute accumulator |
| fault_cnt_i | input | 8 | Saturating fault count |
| fault_map_i | input | ROWS*COLS | Per-row mismatch bits, flattened |
| cells_o | output | ROWS*COLS | Cell array contents, flattened |
| act_vec_o | output | ROWS | Activation vector |
| start_bist_o | output | 1 | Self-test start pulse |
| start_cim_o | output | 1 | Compute start pulse |
| clear_fault_o | output | 1 | Fault-map clear pulse |
| bist_done_o | output | 1 | Sticky self-test done |
| cim_done_o | output | 1 | Sticky compute done |
| fault_ever_o | output | 1 | Sticky any-fault |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: ROWS=8, COLS=8, ACC_W=16 and a two-stage synchroniser. With eight rows, the three-bit row pointer covers every row, and a pointer of 9 reaches the out-of-range path. With a 16-bit accumulator, the high-byte register carries real data rather than zero padding. With two synchroniser stages, the frame decoder must have the read byte loaded before the ninth rising SCK edge, which the bench samples at that edge.

// File: rtl/crim_pkg.sv
package crim_pkg;

   localparam int unsigned DATA_W  = 8;
   localparam int unsigned ADDR_W  = 7;
   localparam int unsigned FRAME_W = 1 + ADDR_W + DATA_W;

   typedef enum logic [ADDR_W-1:0] {
      RA_CMD      = 7'h00,
      RA_FLAGS    = 7'h01,
      RA_ROW_PTR  = 7'h02,
      RA_ROW_DATA = 7'h03,
      RA_ACT      = 7'h04,
      RA_ACC_LO   = 7'h05,
      RA_ACC_HI   = 7'h06,
      RA_FLT_PTR  = 7'h07,
      RA_FLT_DATA = 7'h08,
      RA_FLT_CNT  = 7'h09
   } reg_addr_e;

   // command register bit positions
   localparam int unsigned CMD_BIST  = 0;
   localparam int unsigned CMD_CIM   = 1;
   localparam int unsigned CMD_CLR   = 2;
   localparam int unsigned CMD_IRQEN = 7;

   // status register bit positions
   localparam int unsigned ST_BUSY  = 0;
   localparam int unsigned ST_BIST  = 5;
   localparam int unsigned ST_CIM   = 6;
   localparam int unsigned ST_FAULT = 7;

   // sticky flag vector ordering
   localparam int unsigned FL_BIST  = 0;
   localparam int unsigned FL_CIM   = 1;
   localparam int unsigned FL_FAULT = 2;
   localparam int unsigned FL_N     = 3;

endpackage

// File: rtl/crim_sync.sv
module crim_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] rst_val,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES == 0) begin : g_bypass
      logic [W-1:0] unused_rv;
      assign unused_rv = rst_val;
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stg_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= rst_val;
         end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
         end
      end
      assign q = stg_q[STAGES-1];
   end

endmodule

// File: rtl/crim_frame.sv
module crim_frame
   import crim_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              cs_n_s,
   input  logic              mosi_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              miso
);

   localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
   localparam int unsigned HDR_END = 1 + ADDR_W;

   logic              sck_q;
   logic              sck_rise, sck_fall;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-2:0] rx_sr;
   logic [DATA_W-1:0] tx_sr;
   logic              rd_dir;
   logic              load_pend;
   logic [DATA_W-1:0] rx_byte;

   assign sck_rise = sck_s & ~sck_q;
   assign sck_fall = ~sck_s & sck_q;
   assign rx_byte  = {rx_sr, mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sr     <= '0;
         tx_sr     <= '0;
         rd_dir    <= 1'b0;
         addr      <= '0;
         load_pend <= 1'b0;
         wr_en     <= 1'b0;
         wr_data   <= '0;
      end else begin
         wr_en     <= 1'b0;
         load_pend <= 1'b0;
         if (cs_n_s) begin
            bit_cnt <= '0;
            tx_sr   <= '0;
         end else begin
            if (load_pend) tx_sr <= rd_dir ? rd_data : '0;
            if (sck_rise && bit_cnt < CNT_W'(FRAME_W)) begin
               rx_sr   <= rx_byte[DATA_W-2:0];
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == CNT_W'(HDR_END - 1)) begin
                  rd_dir    <= rx_byte[DATA_W-1];
                  addr      <= rx_byte[ADDR_W-1:0];
                  load_pend <= 1'b1;
               end
               if (bit_cnt == CNT_W'(FRAME_W - 1)) begin
                  wr_en   <= ~rd_dir;
                  wr_data <= rx_byte;
               end
            end else if (sck_fall && bit_cnt > CNT_W'(HDR_END)) begin
               tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign miso = tx_sr[DATA_W-1];

endmodule

// File: rtl/crim_sticky.sv
module crim_sticky #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flag
);

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flag[i] <= 1'b0;
         else if (set[i]) flag[i] <= 1'b1;
         else if (clr[i]) flag[i] <= 1'b0;
      end
   end

endmodule

// File: rtl/crim_regfile.sv
module crim_regfile
   import crim_pkg::*;
#(
   parameter int unsigned ROWS  = 8,
   parameter int unsigned COLS  = 8,
   parameter int unsigned ACC_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   input  logic                 busy_i,
   input  logic [FL_N-1:0]      flag_set,
   input  logic [ACC_W-1:0]     accum_i,
   input  logic [7:0]           fault_cnt_i,
   input  logic [ROWS*COLS-1:0] fault_map_i,
   output logic [ROWS*COLS-1:0] cells_o,
   output logic [ROWS-1:0]      act_vec_o,
   output logic                 start_bist_o,
   output logic                 start_cim_o,
   output logic                 clear_fault_o,
   output logic [FL_N-1:0]      flags_o,
   output logic                 irq_o
);

   localparam int unsigned RSEL_W = $clog2(ROWS);

   logic [COLS-1:0]   cell_q [ROWS];
   logic [DATA_W-1:0] row_ptr_q, flt_ptr_q, act_q;
   logic              irq_en_q;
   logic              row_ok, flt_ok;
   logic [RSEL_W-1:0] row_idx, flt_idx;
   logic [FL_N-1:0]   flag_clr;
   logic [15:0]       acc_ext;
   logic              wr_cmd, wr_flags;

   assign row_ok  = row_ptr_q < DATA_W'(ROWS);
   assign flt_ok  = flt_ptr_q < DATA_W'(ROWS);
   assign row_idx = row_ptr_q[RSEL_W-1:0];
   assign flt_idx = flt_ptr_q[RSEL_W-1:0];
   assign acc_ext = 16'(accum_i);
   assign wr_cmd   = wr_en && addr == RA_CMD;
   assign wr_flags = wr_en && addr == RA_FLAGS;

   // plain storage registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_ptr_q <= '0;
         flt_ptr_q <= '0;
         act_q     <= '0;
         irq_en_q  <= 1'b0;
      end else if (wr_en) begin
         case (addr)
            RA_CMD:     irq_en_q  <= wdata[CMD_IRQEN];
            RA_ROW_PTR: row_ptr_q <= wdata;
            RA_ACT:     act_q     <= wdata;
            RA_FLT_PTR: flt_ptr_q <= wdata;
            default: ;
         endcase
      end
   end

   // cell array rows
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q[r] <= '0;
         else if (wr_en && addr == RA_ROW_DATA && row_ok && row_idx == RSEL_W'(r))
            cell_q[r] <= wdata[COLS-1:0];
      end
      assign cells_o[r*COLS +: COLS] = cell_q[r];
   end

   // command pulses
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_bist_o  <= 1'b0;
         start_cim_o   <= 1'b0;
         clear_fault_o <= 1'b0;
      end else begin
         start_bist_o  <= wr_cmd && wdata[CMD_BIST];
         start_cim_o   <= wr_cmd && wdata[CMD_CIM];
         clear_fault_o <= wr_cmd && wdata[CMD_CLR];
      end
   end

   // sticky status flags
   always_comb begin
      flag_clr           = '0;
      flag_clr[FL_BIST]  = wr_flags && wdata[ST_BIST];
      flag_clr[FL_CIM]   = wr_flags && wdata[ST_CIM];
      flag_clr[FL_FAULT] = (wr_flags && wdata[ST_FAULT]) || clear_fault_o;
   end

   crim_sticky #(.N(FL_N)) u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .clr   (flag_clr),
      .flag  (flags_o)
   );

   assign irq_o     = irq_en_q && (flags_o[FL_BIST] || flags_o[FL_CIM]);
   assign act_vec_o = act_q[ROWS-1:0];

   // read mux
   always_comb begin
      rdata = '0;
      case (addr)
         RA_CMD:      rdata[CMD_IRQEN] = irq_en_q;
         RA_FLAGS: begin
            rdata[ST_BUSY]  = busy_i;
            rdata[ST_BIST]  = flags_o[FL_BIST];
            rdata[ST_CIM]   = flags_o[FL_CIM];
            rdata[ST_FAULT] = flags_o[FL_FAULT];
         end
         RA_ROW_PTR:  rdata = row_ptr_q;
         RA_ROW_DATA: rdata = row_ok ? DATA_W'(cell_q[row_idx]) : '0;
         RA_ACT:      rdata = act_q;
         RA_ACC_LO:   rdata = acc_ext[7:0];
         RA_ACC_HI:   rdata = acc_ext[15:8];
         RA_FLT_PTR:  rdata = flt_ptr_q;
         RA_FLT_DATA: rdata = flt_ok ? DATA_W'(fault_map_i[flt_idx*COLS +: COLS]) : '0;
         RA_FLT_CNT:  rdata = fault_cnt_i;
         default:     rdata = '0;
      endcase
   end

endmodule

// File: rtl/crim_regbank.sv
module crim_regbank
   import crim_pkg::*;
#(
   parameter int unsigned ROWS        = 8,
   parameter int unsigned COLS        = 8,
   parameter int unsigned ACC_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 spi_sck,
   input  logic                 spi_cs_n,
   input  logic                 spi_mosi,
   output logic                 spi_miso,
   input  logic                 busy_i,
   input  logic                 bist_done_set_i,
   input  logic                 cim_done_set_i,
   input  logic                 fault_set_i,
   input  logic [ACC_W-1:0]     accum_i,
   input  logic [7:0]           fault_cnt_i,
   input  logic [ROWS*COLS-1:0] fault_map_i,
   output logic [ROWS*COLS-1:0] cells_o,
   output logic [ROWS-1:0]      act_vec_o,
   output logic                 start_bist_o,
   output logic                 start_cim_o,
   output logic                 clear_fault_o,
   output logic                 bist_done_o,
   output logic                 cim_done_o,
   output logic                 fault_ever_o,
   output logic                 irq_o
);

   // elaboration-time parameter checks
   if (ROWS < 2 || ROWS > DATA_W) begin : g_bad_rows
      $error("ROWS must lie in 2..8");
   end
   if (COLS < 1 || COLS > DATA_W) begin : g_bad_cols
      $error("COLS must lie in 1..8");
   end
   if (ACC_W < 1 || ACC_W > 16) begin : g_bad_acc
      $error("ACC_W must lie in 1..16");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must not exceed 4");
   end

   logic [2:0]        pins_s;
   logic [ADDR_W-1:0] f_addr;
   logic              f_wr;
   logic [DATA_W-1:0] f_wdata, f_rdata;
   logic [FL_N-1:0]   fl_set, fl_q;

   crim_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .rst_val (3'b010),
      .d       ({spi_sck, spi_cs_n, spi_mosi}),
      .q       (pins_s)
   );

   crim_frame u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .sck_s   (pins_s[2]),
      .cs_n_s  (pins_s[1]),
      .mosi_s  (pins_s[0]),
      .rd_data (f_rdata),
      .addr    (f_addr),
      .wr_en   (f_wr),
      .wr_data (f_wdata),
      .miso    (spi_miso)
   );

   always_comb begin
      fl_set           = '0;
      fl_set[FL_BIST]  = bist_done_set_i;
      fl_set[FL_CIM]   = cim_done_set_i;
      fl_set[FL_FAULT] = fault_set_i;
   end

   crim_regfile #(.ROWS(ROWS), .COLS(COLS), .ACC_W(ACC_W)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (f_wr),
      .addr          (f_addr),
      .wdata         (f_wdata),
      .rdata         (f_rdata),
      .busy_i        (busy_i),
      .flag_set      (fl_set),
      .accum_i       (accum_i),
      .fault_cnt_i   (fault_cnt_i),
      .fault_map_i   (fault_map_i),
      .cells_o       (cells_o),
      .act_vec_o     (act_vec_o),
      .start_bist_o  (start_bist_o),
      .start_cim_o   (start_cim_o),
      .clear_fault_o (clear_fault_o),
      .flags_o       (fl_q),
      .irq_o         (irq_o)
   );

   assign bist_done_o  = fl_q[FL_BIST];
   assign cim_done_o   = fl_q[FL_CIM];
   assign fault_ever_o = fl_q[FL_FAULT];

endmodule

// File: rtl/crim_regbank_chk.sv
module crim_regbank_chk (
   input logic clk,
   input logic rst_n,
   input logic start_bist_o,
   input logic start_cim_o,
   input logic clear_fault_o,
   input logic bist_done_set_i,
   input logic cim_done_set_i,
   input logic fault_set_i,
   input logic bist_done_o,
   input logic cim_done_o,
   input logic fault_ever_o,
   input logic irq_o
);

   a_r5_bist_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
      start_bist_o |=> !start_bist_o);

   a_r5_cim_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
      start_cim_o |=> !start_cim_o);

   a_r5_clr_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
      clear_fault_o |=> !clear_fault_o);

   a_r6_cim_set: assert property (@(posedge clk) disable iff (!rst_n)
      cim_done_set_i |=> cim_done_o);

   a_r6_bist_set: assert property (@(posedge clk) disable iff (!rst_n)
      bist_done_set_i |=> bist_done_o);

   a_r6_no_fall_on_set: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cim_done_o) |-> !$past(cim_done_set_i));

   a_r7_fault_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_fault_o && !fault_set_i) |=> !fault_ever_o);

   a_r8_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (bist_done_o || cim_done_o));

endmodule

bind crim_regbank crim_regbank_chk u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .start_bist_o    (start_bist_o),
   .start_cim_o     (start_cim_o),
   .clear_fault_o   (clear_fault_o),
   .bist_done_set_i (bist_done_set_i),
   .cim_done_set_i  (cim_done_set_i),
   .fault_set_i     (fault_set_i),
   .bist_done_o     (bist_done_o),
   .cim_done_o      (cim_done_o),
   .fault_ever_o    (fault_ever_o),
   .irq_o           (irq_o)
);

// File: tb/tb_crim_regbank.sv
module tb_crim_regbank;

   localparam int ROWS = 8, COLS = 8, ACC_W = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, spi_miso;
   logic busy_i = 1'b0, bist_done_set_i = 1'b0, cim_done_set_i = 1'b0, fault_set_i = 1'b0;
   logic [ACC_W-1:0]     accum_i = '0;
   logic [7:0]           fault_cnt_i = '0;
   logic [ROWS*COLS-1:0] fault_map_i = '0;
   logic [ROWS*COLS-1:0] cells_o;
   logic [ROWS-1:0]      act_vec_o;
   logic start_bist_o, start_cim_o, clear_fault_o;
   logic bist_done_o, cim_done_o, fault_ever_o, irq_o;

   int n_chk = 0, n_bad = 0;
   int cnt_bist = 0, cnt_cim = 0, cnt_clr = 0;

   always #4 clk = ~clk;

   crim_regbank dut (.*);

   always @(negedge clk) begin
      if (start_bist_o)  cnt_bist++;
      if (start_cim_o)   cnt_cim++;
      if (clear_fault_o) cnt_clr++;
   end

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic spi_xfer(input bit rw, input logic [6:0] a, input logic [7:0] d,
                           input int nbits, output logic [7:0] rd);
      logic [15:0] f;
      f  = {rw, a, d};
      rd = '0;
      @(negedge clk);
      spi_cs_n = 1'b0;
      repeat (8) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         spi_mosi = f[15-i];
         repeat (8) @(negedge clk);
         spi_sck = 1'b1;
         if (i >= 8) rd[15-i] = spi_miso;
         repeat (8) @(negedge clk);
         spi_sck = 1'b0;
      end
      repeat (8) @(negedge clk);
      spi_cs_n = 1'b1;
      spi_mosi = 1'b0;
      repeat (16) @(negedge clk);
   endtask

   task automatic wr(input logic [6:0] a, input logic [7:0] d);
      logic [7:0] dummy;
      spi_xfer(1'b0, a, d, 16, dummy);
   endtask

   task automatic rd(input logic [6:0] a, output logic [7:0] v);
      spi_xfer(1'b1, a, 8'h00, 16, v);
   endtask

   task automatic strobe(input int which);
      @(negedge clk);
      case (which)
         0: bist_done_set_i = 1'b1;
         1: cim_done_set_i  = 1'b1;
         default: fault_set_i = 1'b1;
      endcase
      @(negedge clk);
      bist_done_set_i = 1'b0;
      cim_done_set_i  = 1'b0;
      fault_set_i     = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      check("R11 cells", cells_o, 64'h0);
      check("R11 irq/flags", {irq_o, bist_done_o, cim_done_o, fault_ever_o}, 4'h0);
      check("R11 pulses", {start_bist_o, start_cim_o, clear_fault_o}, 3'h0);
      rd(7'h00, v); check("R11 cmd reg", v, 8'h00);
      rd(7'h01, v); check("R11 status reg", v, 8'h00);
      rd(7'h04, v); check("R11 act reg", v, 8'h00);
   endtask

   task automatic t_cells;
      logic [7:0] v;
      wr(7'h02, 8'd3); wr(7'h03, 8'hA5);
      wr(7'h02, 8'd5); wr(7'h03, 8'h3C);
      wr(7'h02, 8'd3); rd(7'h03, v);
      check("R2 row3 readback", v, 8'hA5);
      rd(7'h02, v); check("R2 row pointer", v, 8'd3);
      check("R2 cells_o", cells_o, 64'h0000_3C00_A500_0000);
      wr(7'h02, 8'd9); wr(7'h03, 8'hFF); rd(7'h03, v);
      check("R2 out-of-range row reads 0", v, 8'h00);
      check("R2 out-of-range write ignored", cells_o, 64'h0000_3C00_A500_0000);
   endtask

   task automatic t_act;
      logic [7:0] v;
      wr(7'h04, 8'h96); rd(7'h04, v);
      check("R3 act readback", v, 8'h96);
      check("R3 act_vec_o", act_vec_o, 8'h96);
   endtask

   task automatic t_readonly;
      logic [7:0] v;
      accum_i = 16'h1234; fault_cnt_i = 8'h2A;
      fault_map_i = 64'h0000_0000_0081_0000;
      rd(7'h05, v); check("R1 R4 accum lo", v, 8'h34);
      rd(7'h06, v); check("R4 accum hi", v, 8'h12);
      wr(7'h07, 8'd2); rd(7'h08, v); check("R4 fault row 2", v, 8'h81);
      rd(7'h09, v); check("R4 fault count", v, 8'h2A);
   endtask

   task automatic t_ctrl;
      logic [7:0] v;
      cnt_bist = 0; cnt_cim = 0; cnt_clr = 0;
      wr(7'h00, 8'h87);
      check("R5 bist pulse count", cnt_bist, 1);
      check("R5 cim pulse count", cnt_cim, 1);
      check("R5 clear pulse count", cnt_clr, 1);
      rd(7'h00, v); check("R5 cmd readback", v, 8'h80);
   endtask

   task automatic t_status;
      logic [7:0] v;
      busy_i = 1'b1;
      strobe(0); strobe(1); strobe(2);
      rd(7'h01, v); check("R6 all flags set", v, 8'hE1);
      check("R8 irq with enable", irq_o, 1'b1);
      wr(7'h01, 8'h40); rd(7'h01, v); check("R6 clear compute bit6", v, 8'hA1);
      wr(7'h01, 8'h00); rd(7'h01, v); check("R6 zero write no effect", v, 8'hA1);
      check("R8 irq still on bist done", irq_o, 1'b1);
      wr(7'h01, 8'h20); rd(7'h01, v); check("R6 clear selftest", v, 8'h81);
      check("R8 irq low, no done", irq_o, 1'b0);
      wr(7'h00, 8'h84); rd(7'h01, v); check("R7 clear pulse drops fault", v, 8'h01);
      strobe(1); wr(7'h00, 8'h00);
      check("R8 irq low when disabled", irq_o, 1'b0);
      wr(7'h01, 8'h40);
      busy_i = 1'b0;
   endtask

   task automatic t_abort;
      logic [7:0] v;
      spi_xfer(1'b0, 7'h04, 8'h5A, 12, v);
      rd(7'h04, v); check("R9 aborted write ignored", v, 8'h96);
   endtask

   task automatic t_unmapped;
      logic [7:0] v;
      wr(7'h30, 8'h55); rd(7'h30, v); check("R10 unmapped read zero", v, 8'h00);
      rd(7'h04, v); check("R10 act untouched", v, 8'h96);
      check("R10 cells untouched", cells_o, 64'h0000_3C00_A500_0000);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_cells();
      t_act();
      t_readonly();
      t_ctrl();
      t_status();
      t_abort();
      t_unmapped();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 190000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule